// File: doc/BRIEF.md
# Contiguous Run Allocator over a Usage Bitmap

This block keeps a record of which allocation units of a 64-unit memory region are taken. Each unit has one bit. A clear bit means the unit is free and a set bit means it is in use. A requester asks for a number of adjacent units and names a placement policy. The block walks the record one unit per clock and looks for a free stretch that is long enough. It then marks the stretch as used and answers with the index of its first unit. If no stretch fits, it answers with a failure flag.

A release request names a first unit and a count. The block clears those bits, so the released stretch joins any free units on either side. Requests use a valid/ready handshake. Only one request is open at a time. Every request gets exactly one single-cycle response pulse.

The controller has four named states:
- ST_IDLE: ready is high and a request can be taken.
- ST_SCAN: the walk over the units, one unit per cycle, plus one cycle for the end-of-region marker.
- ST_COMMIT: the chosen stretch is written.
- ST_RESP: the response pulse.

Its transitions are:
- ST_IDLE to ST_SCAN on a well-formed allocate.
- ST_IDLE to ST_RESP on a release or on a rejected allocate.
- ST_SCAN to ST_COMMIT after the marker position.
- ST_COMMIT to ST_RESP, always.
- ST_RESP to ST_IDLE, always.

Top module: `bitmap_run_alloc`

## Requirements
- R1: After reset, all 64 units are free, `req_ready` is 1 and `rsp_valid` is 0.
- R2: With `req_policy` 0 (first-fit), or with the unused code 3, an allocate returns the lowest-indexed free stretch whose length is at least `req_len`.
- R3: With `req_policy` 1 (best-fit), an allocate takes the shortest free stretch whose length is at least `req_len`. If stretches tie, the one with the lowest index wins.
- R4: With `req_policy` 2 (worst-fit), an allocate takes the longest free stretch, as long as its length is at least `req_len`. If stretches tie, the one with the lowest index wins.
- R5: A successful allocate reports `rsp_ok`=1 and `rsp_start`=s. It marks exactly units s through s+n-1 as used, and no unit outside that range.
- R6: When no free stretch is long enough, the allocate reports `rsp_ok`=0 and the bitmap does not change.
- R7: An allocate with `req_len` equal to 0 or greater than 64 is rejected. It reports `rsp_ok`=0 in the cycle right after the accepting edge and changes nothing.
- R8: A release (`req_op`=1) with `req_len`≥1 and `req_base`+`req_len`≤64 clears those units and reports `rsp_ok`=1 in the cycle right after the accepting edge. The cleared units merge with neighbouring free units. A release with length 0, or one that runs past unit 63, reports `rsp_ok`=0 and changes nothing.
- R9: For a well-formed allocate, `rsp_valid` is high for one cycle, 66 clock edges after the accepting edge. `req_ready` stays low from acceptance until the response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | A request can be taken (high only in ST_IDLE) |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_policy | input | 2 | 0 first-fit, 1 best-fit, 2 worst-fit, 3 first-fit |
| req_len | input | 7 | Number of units |
| req_base | input | 6 | First unit of a release |
| rsp_valid | output | 1 | Single-cycle response pulse |
| rsp_ok | output | 1 | Request succeeded |
| rsp_start | output | 6 | First unit of a granted stretch (or the release base) |

## Verification
The bench goes after the policy choices:
- Among several free stretches of different sizes, best-fit must take the shortest one and worst-fit the longest one. A design that swapped the comparisons, or that favoured the latest tie, would return the wrong start index.
- A release that sits next to an existing free unit must produce a merged stretch that a later first-fit can grant. A design that cleared one unit too few or too many would misplace that grant or fail it.

It also checks the region ends and the edge cases of the request fields:
- A request for the full region and a run that ends at unit 63 are both covered. A design that lost the final run at the region end would fail them.
- Requests of length 0 and length 65, and a release that runs past the end, are covered. A design that accepted any of these would corrupt the map. A later allocation would show that corruption.
- The exact response latency is checked, so a miscounted scan length shows up.

// File: rtl/runalloc_pkg.sv
package runalloc_pkg;

    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_FREE  = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        POL_FIRST     = 2'd0,
        POL_BEST      = 2'd1,
        POL_WORST     = 2'd2,
        POL_FIRST_ALT = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_COMMIT,
        ST_RESP
    } state_e;

endpackage

// File: rtl/runalloc_map.sv
module runalloc_map #(
    parameter int UNITS = 64,
    parameter int LW    = $clog2(UNITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [LW-1:0]    lo,
    input  logic [LW-1:0]    cnt,
    output logic [UNITS-1:0] map
);

    logic [UNITS-1:0] in_rng;
    logic [LW:0]      hi_excl;

    assign hi_excl = {1'b0, lo} + {1'b0, cnt};

    for (genvar i = 0; i < UNITS; i++) begin : g_rng
        localparam logic [LW:0] IDX = (LW+1)'(i);
        assign in_rng[i] = ({1'b0, lo} <= IDX) && (IDX < hi_excl);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      map <= '0;
        else if (set_en) map <= map | in_rng;
        else if (clr_en) map <= map & ~in_rng;
    end

    // A grant may only cover units that are currently free.
    assert_set_only_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> ((map & in_rng) == '0));

endmodule

// File: rtl/runalloc_scan.sv
module runalloc_scan #(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic          used,
    input  logic [LW-1:0] idx,
    input  logic [LW-1:0] need,
    input  logic [1:0]    pol,
    output logic          found,
    output logic [LW-1:0] cand_start,
    output logic [LW-1:0] cand_len
);
    import runalloc_pkg::*;

    logic [LW-1:0] cur_len;
    logic [LW-1:0] cur_start;
    logic          take;

    always_comb begin
        unique case (policy_e'(pol))
            POL_BEST:  take = !found || (cur_len < cand_len);
            POL_WORST: take = !found || (cur_len > cand_len);
            default:   take = !found;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cur_len    <= '0;
            cur_start  <= '0;
            found      <= 1'b0;
            cand_start <= '0;
            cand_len   <= '0;
        end else if (step) begin
            if (!used) begin
                if (cur_len == '0) cur_start <= idx;
                cur_len <= cur_len + 1'b1;
            end else begin
                if ((cur_len >= need) && take) begin
                    found      <= 1'b1;
                    cand_start <= cur_start;
                    cand_len   <= cur_len;
                end
                cur_len <= '0;
            end
        end
    end

    assert_cand_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (cand_len >= need));

    assert_found_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (found && step && !clear) |=> found);

endmodule

// File: rtl/bitmap_run_alloc.sv
module bitmap_run_alloc #(
    parameter int UNITS = 64,
    parameter int IW    = $clog2(UNITS),
    parameter int LW    = $clog2(UNITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_op,
    input  logic [1:0]    req_policy,
    input  logic [LW-1:0] req_len,
    input  logic [IW-1:0] req_base,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic [IW-1:0] rsp_start
);
    import runalloc_pkg::*;

    localparam logic [LW:0]   UNITS_W = (LW+1)'(UNITS);
    localparam logic [LW-1:0] LAST_IX = LW'(UNITS);

    state_e           state, state_nx;
    logic [LW-1:0]    idx;
    logic [LW-1:0]    need;
    logic [1:0]       pol;
    op_e              op_q;
    logic [IW-1:0]    base_q;
    logic             ok_q;
    logic [IW-1:0]    start_q;
    logic [UNITS-1:0] map;

    logic          accept;
    logic          len_ok;
    logic          free_ok;
    logic          used_bit;
    logic          found;
    logic [LW-1:0] cand_start;
    logic [LW-1:0] cand_len;
    logic          set_en, clr_en;
    logic [LW-1:0] wr_lo, wr_cnt;

    assign accept  = req_valid && (state == ST_IDLE);
    assign len_ok  = (req_len != '0) && ({1'b0, req_len} <= UNITS_W);
    assign free_ok = (req_len != '0) &&
                     (({{(LW+1-IW){1'b0}}, req_base} + {1'b0, req_len}) <= UNITS_W);

    // The position after the last unit acts as a used unit and closes the final run.
    assign used_bit = (idx == LAST_IX) ? 1'b1 : map[idx[IW-1:0]];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = (op_e'(req_op) == OP_ALLOC && len_ok) ? ST_SCAN : ST_RESP;
            ST_SCAN:   if (idx == LAST_IX) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_RESP;
            ST_RESP:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        rsp_ok    = ok_q;
        rsp_start = start_q;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            need    <= '0;
            pol     <= '0;
            op_q    <= OP_ALLOC;
            base_q  <= '0;
            ok_q    <= 1'b0;
            start_q <= '0;
        end else begin
            if (accept) begin
                idx     <= '0;
                op_q    <= op_e'(req_op);
                base_q  <= req_base;
                start_q <= req_base;
                ok_q    <= (op_e'(req_op) == OP_FREE) && free_ok;
                if (op_e'(req_op) == OP_ALLOC && len_ok) begin
                    need <= req_len;
                    pol  <= req_policy;
                end
            end else if (state == ST_SCAN) begin
                idx <= idx + 1'b1;
            end else if (state == ST_COMMIT) begin
                ok_q    <= found;
                start_q <= cand_start[IW-1:0];
            end
        end
    end

    assign set_en = (state == ST_COMMIT) && found;
    assign clr_en = accept && (op_e'(req_op) == OP_FREE) && free_ok;
    assign wr_lo  = (state == ST_COMMIT) ? cand_start : {{(LW-IW){1'b0}}, req_base};
    assign wr_cnt = (state == ST_COMMIT) ? need : req_len;

    runalloc_map #(.UNITS(UNITS), .LW(LW)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (set_en),
        .clr_en (clr_en),
        .lo     (wr_lo),
        .cnt    (wr_cnt),
        .map    (map)
    );

    runalloc_scan #(.LW(LW)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .step       (state == ST_SCAN),
        .used       (used_bit),
        .idx        (idx),
        .need       (need),
        .pol        (pol),
        .found      (found),
        .cand_start (cand_start),
        .cand_len   (cand_len)
    );

    assert_busy_after_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_e'(req_op) == OP_ALLOC && len_ok) |=> !req_ready);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_fail_keeps_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> $stable(map));

    assert_grant_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && op_q == OP_ALLOC) |-> map[rsp_start]);

    assert_release_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && op_q == OP_FREE) |-> !map[base_q]);

    assert_reject_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_e'(req_op) == OP_ALLOC && !len_ok) |=> (rsp_valid && !rsp_ok));

endmodule

// File: tb/bitmap_run_alloc_test.sv
module bitmap_run_alloc_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic       req_ready;
    logic       req_op;
    logic [1:0] req_policy;
    logic [6:0] req_len;
    logic [5:0] req_base;
    logic       rsp_valid;
    logic       rsp_ok;
    logic [5:0] rsp_start;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    bitmap_run_alloc uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_policy(req_policy),
        .req_len(req_len), .req_base(req_base),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_start(rsp_start)
    );

    // {req[26:23], op[22], pol[21:20], len[19:13], base[12:7], ok[6], start[5:0]}
    localparam int NV = 29;
    localparam logic [26:0] VEC [NV] = '{
        {4'd2, 1'b0, 2'd0, 7'd10, 6'd0,  1'b1, 6'd0 },  // R2 first grant at 0
        {4'd5, 1'b0, 2'd0, 7'd5,  6'd0,  1'b1, 6'd10},  // R5 unit 10 left free
        {4'd2, 1'b0, 2'd0, 7'd20, 6'd0,  1'b1, 6'd15},
        {4'd5, 1'b0, 2'd0, 7'd29, 6'd0,  1'b1, 6'd35},  // R5 run ends at unit 63
        {4'd6, 1'b0, 2'd0, 7'd1,  6'd0,  1'b0, 6'd0 },  // R6 region full
        {4'd8, 1'b1, 2'd0, 7'd5,  6'd10, 1'b1, 6'd10},  // R8 hole 10..14
        {4'd8, 1'b1, 2'd0, 7'd3,  6'd40, 1'b1, 6'd40},  // hole 40..42
        {4'd8, 1'b1, 2'd0, 7'd8,  6'd50, 1'b1, 6'd50},  // hole 50..57
        {4'd3, 1'b0, 2'd1, 7'd3,  6'd0,  1'b1, 6'd40},  // R3 shortest fitting
        {4'd8, 1'b1, 2'd0, 7'd3,  6'd40, 1'b1, 6'd40},
        {4'd4, 1'b0, 2'd2, 7'd2,  6'd0,  1'b1, 6'd50},  // R4 longest
        {4'd3, 1'b0, 2'd1, 7'd4,  6'd0,  1'b1, 6'd10},  // R3 5 beats 6
        {4'd2, 1'b0, 2'd0, 7'd2,  6'd0,  1'b1, 6'd40},
        {4'd6, 1'b0, 2'd2, 7'd7,  6'd0,  1'b0, 6'd0 },  // R6 largest is 6
        {4'd3, 1'b0, 2'd1, 7'd6,  6'd0,  1'b1, 6'd52},  // also shows R6 no change
        {4'd6, 1'b0, 2'd0, 7'd2,  6'd0,  1'b0, 6'd0 },
        {4'd8, 1'b1, 2'd0, 7'd2,  6'd43, 1'b1, 6'd43},  // R8 joins free unit 42
        {4'd8, 1'b0, 2'd0, 7'd3,  6'd0,  1'b1, 6'd42},  // merged run granted
        {4'd8, 1'b1, 2'd0, 7'd5,  6'd60, 1'b0, 6'd0 },  // R8 past the end
        {4'd7, 1'b0, 2'd0, 7'd0,  6'd0,  1'b0, 6'd0 },  // R7 zero length
        {4'd7, 1'b0, 2'd1, 7'd65, 6'd0,  1'b0, 6'd0 },  // R7 too long
        {4'd8, 1'b1, 2'd0, 7'd0,  6'd5,  1'b0, 6'd0 },  // R8 zero-length release
        {4'd8, 1'b1, 2'd0, 7'd2,  6'd0,  1'b1, 6'd0 },
        {4'd8, 1'b1, 2'd0, 7'd2,  6'd20, 1'b1, 6'd20},
        {4'd3, 1'b0, 2'd1, 7'd2,  6'd0,  1'b1, 6'd0 },  // R3 tie to lowest
        {4'd4, 1'b0, 2'd2, 7'd1,  6'd0,  1'b1, 6'd20},  // R4 longest of 1 and 2
        {4'd2, 1'b0, 2'd3, 7'd1,  6'd0,  1'b1, 6'd14},  // R2 code 3 acts first-fit
        {4'd2, 1'b0, 2'd0, 7'd1,  6'd0,  1'b1, 6'd21},
        {4'd6, 1'b0, 2'd0, 7'd1,  6'd0,  1'b0, 6'd0 }
    };

    task automatic check(input bit good, input int req, input string what,
                         input int act, input int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_req(input logic op, input logic [1:0] pol, input logic [6:0] len,
                          input logic [5:0] base, output logic ok, output logic [5:0] st,
                          output int lat, output bit busy_bad);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_policy = pol; req_len = len; req_base = base;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        busy_bad = 1'b0;
        while (!rsp_valid && lat < 200) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
            lat++;
        end
        ok = rsp_ok;
        st = rsp_start;
    endtask

    task automatic apply(input int req, input logic op, input logic [1:0] pol,
                         input logic [6:0] len, input logic [5:0] base,
                         input logic eok, input logic [5:0] est);
        logic ok;
        logic [5:0] st;
        int lat;
        bit bb;
        int elat;
        do_req(op, pol, len, base, ok, st, lat, bb);
        elat = (op == 1'b0 && len != 0 && len <= 64) ? 66 : 0;
        check(ok == eok, req, "rsp_ok", ok, eok);
        if (eok) check(st == est, req, "rsp_start", st, est);
        check(lat == elat, 9, "latency (R9)", lat, elat);
        check(!bb, 9, "ready low while busy (R9)", bb, 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0;
        req_policy = 2'd0; req_len = '0; req_base = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, 1, "ready after reset (R1)", req_ready, 1);
        check(rsp_valid == 1'b0, 1, "no response after reset (R1)", rsp_valid, 0);

        for (int k = 0; k < NV; k++) begin
            apply(int'(VEC[k][26:23]), VEC[k][22], VEC[k][21:20], VEC[k][19:13],
                  VEC[k][12:7], VEC[k][6], VEC[k][5:0]);
        end

        // Directed: reset clears the whole map (R1), full-region cases
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, 1, "ready after second reset (R1)", req_ready, 1);
        check(rsp_valid == 1'b0, 1, "idle response after second reset (R1)", rsp_valid, 0);
        apply(1, 1'b0, 2'd0, 7'd64, 6'd0, 1'b1, 6'd0);   // R1 all free again
        apply(6, 1'b0, 2'd2, 7'd1,  6'd0, 1'b0, 6'd0);   // R6
        apply(8, 1'b1, 2'd0, 7'd64, 6'd0, 1'b1, 6'd0);   // R8 whole-region release
        apply(4, 1'b0, 2'd2, 7'd64, 6'd0, 1'b1, 6'd0);   // R4
        apply(8, 1'b1, 2'd0, 7'd64, 6'd0, 1'b1, 6'd0);
        apply(3, 1'b0, 2'd1, 7'd1,  6'd0, 1'b1, 6'd0);   // R3 single run
        apply(2, 1'b0, 2'd0, 7'd63, 6'd0, 1'b1, 6'd1);   // R2 remaining tail

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule